// File: doc/BRIEF.md
# Decrementer with Auto-Reload

This block is a 32-bit down-counter that advances by one on every cycle in which a time-base tick enable is high. Software programs it through a single write port with a two-bit register select, and reads any of its four registers back through a combinational read port. The registers are the count, a reload value, a control word and a status word.

When a tick takes the count from one to zero, the block sets a sticky expiry flag in the status word. A level interrupt stays high for as long as that flag and its enable bit in the control word are both set. If the auto-reload bit in the control word is set, the count is loaded with the reload value in place of zero, so the decrementer runs as a periodic timer. Without auto-reload it stops at zero until software writes a new count. Software clears the flag by writing a one to its position in the status word.

Top module: `decr_timer`

## Requirements
- R1: After reset, all four registers read as zero and `irq_o` is low.
- R2: Each cycle with `tick_i` high and a count above one lowers the count by exactly one. A cycle with `tick_i` low leaves the count unchanged.
- R3: A tick while the count is one is the expiry event. It sets the status flag at bit 27 of the status word (select 3).
- R4: Without auto-reload the count goes to zero on expiry and stays there under further ticks. No further expiry event happens, so a cleared flag stays clear, until software writes a new count.
- R5: With auto-reload (control bit 22) set, the expiry event loads the count with the reload register (select 1) on the same edge.
- R6: A count write (select 0) takes priority over a decrement, a reload and the expiry event in the same cycle. The written value is stored and the flag is not set.
- R7: A status write clears the flag when bit 27 of the written data is 1, and leaves it unchanged when that bit is 0.
- R8: If an expiry event and a status write that clears the flag fall in the same cycle, the flag ends up set.
- R9: `irq_o` is high exactly when the flag and the interrupt enable (control bit 26) are both set. It follows any control or status write from the next cycle on.
- R10: The control word (select 2) keeps only bits 26 and 22. Its other bits, and every status bit except 27, read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base tick enable; one decrement step per high cycle |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Write select: 0 count, 1 reload, 2 control, 3 status |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 2 | Read select, same encoding as the write select |
| rd_data_o | output | 32 | Selected register contents (combinational) |
| irq_o | output | 1 | Level interrupt: flag AND enable |

## Verification
The count is first driven with a steady run of ticks and then with idle gaps. This separates a decrement that follows the tick from one that runs freely. Expiry is tried in one-shot mode and in auto-reload mode, and a second full period in the reload case shows the reload value, not a stale count, setting the period. The collision patterns each put two inputs in one cycle: a count write against a tick at one, and a flag clear against an expiry. They show which action wins. The interrupt is toggled through the enable and through status writes with the flag bit at 0 and at 1, which tells the AND apart from either input alone.

// File: rtl/decr_pkg.sv
package decr_pkg;
  localparam int unsigned CNT_W   = 32;
  localparam int unsigned SEL_W   = 2;
  localparam int unsigned FLAG_BIT = 27;
  localparam int unsigned IEN_BIT  = 26;
  localparam int unsigned AREN_BIT = 22;

  typedef enum logic [SEL_W-1:0] {
    SEL_COUNT  = 2'd0,
    SEL_RELOAD = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_STATUS = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/decr_counter.sv
module decr_counter
  import decr_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         auto_en_i,
  input  logic [W-1:0] reload_i,
  output logic [W-1:0] count_o,
  output logic         expire_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_ce;
  logic         nonzero;

  assign nonzero = |cnt_q;

  always_comb begin
    cnt_d    = cnt_q;
    expire_o = 1'b0;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (tick_i && nonzero) begin
      if (cnt_q == ONE) begin
        expire_o = 1'b1;
        cnt_d    = auto_en_i ? reload_i : '0;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  assign cnt_ce = load_i | (tick_i & nonzero);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/decr_regs.sv
module decr_regs
  import decr_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_reload_i,
  input  logic         wr_ctrl_i,
  input  logic         wr_status_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         expire_i,
  output logic [W-1:0] reload_o,
  output logic         irq_en_o,
  output logic         auto_en_o,
  output logic         flag_o
);
  logic [W-1:0] rld_q;
  logic         ien_q, aren_q, flag_q, flag_d, flag_ce;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rld_q <= '0;
    else if (wr_reload_i) rld_q <= wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= 1'b0;
      aren_q <= 1'b0;
    end else if (wr_ctrl_i) begin
      ien_q  <= wr_data_i[IEN_BIT];
      aren_q <= wr_data_i[AREN_BIT];
    end
  end

  // Expiry outranks a clearing write in the same cycle.
  always_comb begin
    flag_d = flag_q;
    if (expire_i) flag_d = 1'b1;
    else if (wr_status_i && wr_data_i[FLAG_BIT]) flag_d = 1'b0;
  end

  assign flag_ce = expire_i | wr_status_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else if (flag_ce) flag_q <= flag_d;
  end

  assign reload_o  = rld_q;
  assign irq_en_o  = ien_q;
  assign auto_en_o = aren_q;
  assign flag_o    = flag_q;
endmodule

// File: rtl/decr_timer.sv
module decr_timer
  import decr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             irq_o
);
  logic             wr_count, wr_reload, wr_ctrl, wr_status;
  logic [CNT_W-1:0] count, reload;
  logic             irq_en, auto_en, flag, expire;

  assign wr_count  = wr_en_i & (wr_sel_i == SEL_COUNT);
  assign wr_reload = wr_en_i & (wr_sel_i == SEL_RELOAD);
  assign wr_ctrl   = wr_en_i & (wr_sel_i == SEL_CTRL);
  assign wr_status = wr_en_i & (wr_sel_i == SEL_STATUS);

  decr_counter #(.W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .load_i     (wr_count),
    .load_val_i (wr_data_i),
    .auto_en_i  (auto_en),
    .reload_i   (reload),
    .count_o    (count),
    .expire_o   (expire)
  );

  decr_regs #(.W(CNT_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_reload_i (wr_reload),
    .wr_ctrl_i   (wr_ctrl),
    .wr_status_i (wr_status),
    .wr_data_i   (wr_data_i),
    .expire_i    (expire),
    .reload_o    (reload),
    .irq_en_o    (irq_en),
    .auto_en_o   (auto_en),
    .flag_o      (flag)
  );

  always_comb begin
    rd_data_o = '0;
    unique case (reg_sel_e'(rd_sel_i))
      SEL_COUNT:  rd_data_o = count;
      SEL_RELOAD: rd_data_o = reload;
      SEL_CTRL: begin
        rd_data_o[IEN_BIT]  = irq_en;
        rd_data_o[AREN_BIT] = auto_en;
      end
      SEL_STATUS: rd_data_o[FLAG_BIT] = flag;
      default:    rd_data_o = '0;
    endcase
  end

  assign irq_o = flag & irq_en;
endmodule

// File: rtl/decr_timer_chk.sv
module decr_timer_chk
  import decr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             wr_en_i,
  input logic [SEL_W-1:0] wr_sel_i,
  input logic [CNT_W-1:0] wr_data_i,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] reload,
  input logic             auto_en,
  input logic             irq_en,
  input logic             flag,
  input logic             expire,
  input logic             irq_o
);
  logic wc, ws;
  assign wc = wr_en_i && (wr_sel_i == SEL_COUNT);
  assign ws = wr_en_i && (wr_sel_i == SEL_STATUS);

  // R2
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !wc && count > 32'd1) |=> (count == $past(count) - 32'd1));

  // R2
  dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !wc) |=> $stable(count));

  // R4
  zero_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == 32'd0 && !wc) |=> (count == 32'd0 && !expire));

  // R5
  reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && auto_en && !(wr_en_i && wr_sel_i == SEL_RELOAD)) |=> (count == $past(reload)));

  // R6
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wc |=> (count == $past(wr_data_i)));

  // R7
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ws && wr_data_i[FLAG_BIT] && !expire) |=> !flag);

  // R8
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag);

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flag && irq_en));
endmodule

bind decr_timer decr_timer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_i    (tick_i),
  .wr_en_i   (wr_en_i),
  .wr_sel_i  (wr_sel_i),
  .wr_data_i (wr_data_i),
  .count     (count),
  .reload    (reload),
  .auto_en   (auto_en),
  .irq_en    (irq_en),
  .flag      (flag),
  .expire    (expire),
  .irq_o     (irq_o)
);

// File: tb/sim_decr_timer.sv
`timescale 1ns/1ps
module sim_decr_timer;
  logic        clk, rst_n, tick, wr_en, irq;
  logic [1:0]  wr_sel, rd_sel;
  logic [31:0] wr_data, rd_data;
  int checks, errors;

  localparam logic [31:0] FLAG = 32'h0800_0000; // bit 27
  localparam logic [31:0] IEN  = 32'h0400_0000; // bit 26
  localparam logic [31:0] AREN = 32'h0040_0000; // bit 22

  decr_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_sel_i(wr_sel), .wr_data_i(wr_data), .rd_sel_i(rd_sel),
    .rd_data_o(rd_data), .irq_o(irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    rd_sel = s;
    #0.5;
    v = rd_data;
  endtask

  // One clock: drive at negedge, return at the next negedge.
  task automatic step(input logic we, input logic [1:0] s, input logic [31:0] d, input logic tk);
    wr_en = we; wr_sel = s; wr_data = d; tick = tk;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0; wr_data = '0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    step(1'b1, s, d, 1'b0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, 32'd0, 1'b1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), v);
      chk($sformatf("R1 reg%0d after reset", s), v, 32'd0);
    end
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_count();
    logic [31:0] v;
    wr(2'd0, 32'd5);
    ticks(3);
    rd(2'd0, v); chk("R2 three ticks from 5", v, 32'd2);
    step(1'b0, 2'd0, 32'd0, 1'b0);
    step(1'b0, 2'd0, 32'd0, 1'b0);
    rd(2'd0, v); chk("R2 idle cycles hold count", v, 32'd2);
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    wr(2'd0, 32'd3);
    ticks(2);
    rd(2'd3, v); chk("R3 flag clear before expiry", v, 32'd0);
    ticks(1);
    rd(2'd3, v); chk("R3 flag set at expiry", v, FLAG);
    rd(2'd0, v); chk("R4 count zero after expiry", v, 32'd0);
    chk("R9 irq low with enable off", {31'd0, irq}, 32'd0);
    wr(2'd3, FLAG);
    ticks(4);
    rd(2'd0, v); chk("R4 count parked at zero", v, 32'd0);
    rd(2'd3, v); chk("R4 no further expiry", v, 32'd0);
  endtask

  task automatic t_reload();
    logic [31:0] v;
    wr(2'd1, 32'd4);
    wr(2'd2, AREN);
    wr(2'd0, 32'd2);
    ticks(2);
    rd(2'd0, v); chk("R5 reload on expiry", v, 32'd4);
    rd(2'd3, v); chk("R5 flag set on reload expiry", v, FLAG);
    wr(2'd3, FLAG);
    ticks(3);
    rd(2'd3, v); chk("R5 no event mid period", v, 32'd0);
    ticks(1);
    rd(2'd0, v); chk("R5 second period reload", v, 32'd4);
    rd(2'd3, v); chk("R5 second period flag", v, FLAG);
    wr(2'd3, FLAG);
    wr(2'd2, 32'd0);
  endtask

  task automatic t_prio();
    logic [31:0] v;
    wr(2'd0, 32'd1);
    step(1'b1, 2'd0, 32'd9, 1'b1);
    rd(2'd0, v); chk("R6 write beats tick at one", v, 32'd9);
    rd(2'd3, v); chk("R6 no flag when write wins", v, 32'd0);
    wr(2'd1, 32'd7);
    wr(2'd2, AREN);
    wr(2'd0, 32'd1);
    step(1'b1, 2'd0, 32'd20, 1'b1);
    rd(2'd0, v); chk("R6 write beats reload", v, 32'd20);
    step(1'b1, 2'd0, 32'd11, 1'b1);
    rd(2'd0, v); chk("R6 write beats decrement", v, 32'd11);
    wr(2'd2, 32'd0);
  endtask

  task automatic t_race();
    logic [31:0] v;
    wr(2'd0, 32'd2);
    ticks(2);
    rd(2'd3, v); chk("R8 flag set before race", v, FLAG);
    wr(2'd0, 32'd1);
    step(1'b1, 2'd3, FLAG, 1'b1);
    rd(2'd3, v); chk("R8 expiry beats clear", v, FLAG);
    wr(2'd3, FLAG);
    rd(2'd3, v); chk("R7 clear after race", v, 32'd0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(2'd2, IEN);
    wr(2'd0, 32'd1);
    chk("R9 irq low before expiry", {31'd0, irq}, 32'd0);
    ticks(1);
    chk("R9 irq high on flag and enable", {31'd0, irq}, 32'd1);
    wr(2'd2, 32'd0);
    chk("R9 irq drops with enable", {31'd0, irq}, 32'd0);
    wr(2'd2, IEN);
    chk("R9 irq returns with enable", {31'd0, irq}, 32'd1);
    wr(2'd3, ~FLAG);
    rd(2'd3, v); chk("R7 zero in bit 27 keeps flag", v, FLAG);
    chk("R7 irq kept", {31'd0, irq}, 32'd1);
    wr(2'd3, FLAG);
    rd(2'd3, v); chk("R7 one in bit 27 clears flag", v, 32'd0);
    chk("R9 irq low after clear", {31'd0, irq}, 32'd0);
    wr(2'd2, 32'd0);
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, v); chk("R10 control keeps two bits", v, IEN | AREN);
    wr(2'd2, 32'd0);
    rd(2'd2, v); chk("R10 control cleared", v, 32'd0);
    wr(2'd1, 32'hDEAD_BEEF);
    rd(2'd1, v); chk("R10 reload readback", v, 32'hDEAD_BEEF);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    tick = 0; wr_en = 0; wr_sel = 0; wr_data = 0; rd_sel = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_oneshot();
    t_reload();
    t_prio();
    t_race();
    t_irq();
    t_ctrl();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule